// File: doc/BRIEF.md
# Per-Pin Bidirectional Fast GPIO Multiplexer

This block sits between a processor's fast I/O registers and a bank of shared pads. A fast output word drives the pad data lines and a fast input word reports pad levels back to the processor. Each pin has its own direction scheme, picked by a mode bit. In output-only mode the pad is always driven and the processor sees a constant zero on that input bit. In bidirectional mode a per-pin direction bit decides whether the pad buffer is enabled. That direction bit is taken from a spare output-enable bank belonging to a neighbouring I/O controller.

Both the mode word and the direction word live in a small register pair. Software writes them through a synchronous port with an address, write data and a strobe. The stored word at the addressed location reads back at any time. The pad data line always carries the processor's output bit. Only the tri-state control changes with direction. Pad levels pass through a two-flop synchronizer before they reach the input word.

Top module: `gpio_bidi_mux`

## Requirements
- R1: After reset the mode word and the direction word both read back as zero, every pad enable is 1 (driven), and the input word is zero.
- R2: A pin whose mode bit is 0 has its pad enable at 1, whatever its direction bit holds.
- R3: A pin whose mode bit is 0 shows 0 in the input word, whatever level its pad carries.
- R4: A pin whose mode bit is 1 and whose direction bit is 1 has its pad enable at 0, so the pad is sampled and not driven.
- R5: A pin whose mode bit is 1 and whose direction bit is 0 has its pad enable at 1.
- R6: The pad data word equals the processor output word at all times, in every mode.
- R7: For a pin whose mode bit is 1, the input-word bit equals the pad level sampled two rising clock edges earlier.
- R8: With the write strobe high, address 0 loads the mode word and address 1 loads the direction word at the rising edge. The read data shows the word selected by the address: 0 for mode, 1 for direction.
- R9: With the write strobe low, neither stored word changes, whatever the address and write data carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 mode word, 1 direction word |
| cfg_wdata | input | 20 | Configuration write data |
| cfg_rdata | output | 20 | Read-back of the addressed configuration word |
| gpo_word | input | 20 | Processor fast output word |
| pad_in | input | 20 | Levels observed on the pads |
| pad_out | output | 20 | Data driven toward the pads |
| pad_oe | output | 20 | Pad buffer enable, 1 drives the pad |
| gpi_word | output | 20 | Processor fast input word |

## Verification
The properties assume that the reset reaching the block is already deasserted in step with the clock. They also assume that the pad, output and configuration inputs are always known values, never X. The latency check assumes the pad word is a legal level on every edge and not only on the edges where it changes. The bench drives every input from time zero and changes stimulus only on falling edges. It releases reset away from rising edges, so every sampled edge sees settled, defined inputs.

// File: rtl/gpio_bidi_pkg.sv
package gpio_bidi_pkg;
  // Register select encoding of the configuration port
  typedef enum logic [0:0] {
    CFG_MODE = 1'b0,
    CFG_DIR  = 1'b1
  } cfg_reg_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bidi_pkg::*;
#(
  parameter int NPIN = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  output logic [NPIN-1:0] mode_q,
  output logic [NPIN-1:0] dir_q
);
  logic            mode_ld, dir_ld;
  logic [NPIN-1:0] mode_d, dir_d;

  // next-state
  always_comb begin
    mode_ld = we && (cfg_reg_e'(addr) == CFG_MODE);
    dir_ld  = we && (cfg_reg_e'(addr) == CFG_DIR);
    mode_d  = wdata;
    dir_d   = wdata;
  end

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_ld) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_ld) begin
      dir_q <= dir_d;
    end
  end

  always_comb begin
    rdata = (cfg_reg_e'(addr) == CFG_MODE) ? mode_q : dir_q;
  end

  // R8
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr) |=> (mode_q == $past(wdata)));

  // R8
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr) |=> (dir_q == $past(wdata)));

  // R9
  hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(mode_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q, meta_d, sync_d;

  always_comb begin
    meta_d = async_in;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= meta_d;
      sync_out <= sync_d;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int NPIN = 20
) (
  input  logic [NPIN-1:0] mode,
  input  logic [NPIN-1:0] dir,
  input  logic [NPIN-1:0] out_data,
  input  logic [NPIN-1:0] pad_sync,
  output logic [NPIN-1:0] pad_data,
  output logic [NPIN-1:0] pad_en,
  output logic [NPIN-1:0] in_data
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic sample_only;
    always_comb begin
      // a bidirectional pin with its direction bit set releases the pad
      sample_only = mode[p] & dir[p];
      pad_en[p]   = ~sample_only;
      pad_data[p] = out_data[p];
      // output-only pins feed a constant low to the processor
      in_data[p]  = mode[p] ? pad_sync[p] : 1'b0;
    end
  end
endmodule

// File: rtl/gpio_bidi_mux.sv
module gpio_bidi_mux #(
  parameter int NPIN = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_addr,
  input  logic [NPIN-1:0] cfg_wdata,
  output logic [NPIN-1:0] cfg_rdata,
  input  logic [NPIN-1:0] gpo_word,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] gpi_word
);
  logic [NPIN-1:0] mode_q, dir_q, pad_sync;

  gpio_cfg_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .mode_q(mode_q), .dir_q(dir_q)
  );

  gpio_sync2 #(.WIDTH(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pad_sync)
  );

  gpio_pin_mux #(.NPIN(NPIN)) u_mux (
    .mode(mode_q), .dir(dir_q), .out_data(gpo_word), .pad_sync(pad_sync),
    .pad_data(pad_out), .pad_en(pad_oe), .in_data(gpi_word)
  );

  // cycles since reset release, saturating, for the latency check
  logic [1:0] age_q, age_d;
  always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  // R2
  outonly_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mode_q & ~pad_oe) == '0));

  // R3
  outonly_gpi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mode_q & gpi_word) == '0));

  // R4
  bidi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q & dir_q & pad_oe) == '0));

  // R5
  bidi_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q & ~dir_q & ~pad_oe) == '0));

  // R7
  gpi_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (gpi_word == ($past(pad_in, 2) & mode_q)));
endmodule

// File: tb/sim_gpio_bidi_mux.sv
module sim_gpio_bidi_mux;
  localparam int NPIN = 20;
  localparam logic [NPIN-1:0] ONES = '1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic            cfg_addr = 1'b0;
  logic [NPIN-1:0] cfg_wdata = '0;
  logic [NPIN-1:0] gpo_word = '0;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] cfg_rdata, pad_out, pad_oe, gpi_word;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  gpio_bidi_mux #(.NPIN(NPIN)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .gpo_word(gpo_word),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .gpi_word(gpi_word)
  );

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic check(input string req, input logic [NPIN-1:0] got,
                       input logic [NPIN-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [NPIN-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic a, input string req, input logic [NPIN-1:0] exp);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic check_state(input logic [NPIN-1:0] m, input logic [NPIN-1:0] d,
                             input logic [NPIN-1:0] pad);
    check("R6 pad data", pad_out, gpo_word);
    check("R2 output-only driven", ~m & ~pad_oe, '0);
    check("R4 bidi input released", m & d & pad_oe, '0);
    check("R5 bidi output driven", m & ~d & pad_oe, m & ~d);
    check("R3 output-only input low", ~m & gpi_word, '0);
    check("R7 bidi input level", m & gpi_word, m & pad);
  endtask

  task automatic apply(input logic [NPIN-1:0] m, input logic [NPIN-1:0] d,
                       input logic [NPIN-1:0] o, input logic [NPIN-1:0] pad);
    wr(1'b0, m);
    rd(1'b0, "R8 mode readback", m);
    wr(1'b1, d);
    rd(1'b1, "R8 dir readback", d);
    gpo_word = o; pad_in = pad;
    @(negedge clk);
    @(negedge clk);
    check_state(m, d, pad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [NPIN-1:0] m, d, o, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pad enable", pad_oe, ONES);
    check("R1 input word", gpi_word, '0);
    rd(1'b0, "R1 mode reset", '0);
    rd(1'b1, "R1 dir reset", '0);
    pad_in = ONES; gpo_word = 20'h5A5A5;
    repeat (3) @(negedge clk);
    check("R3 reset input low", gpi_word, '0);
    check("R6 pad data", pad_out, 20'h5A5A5);

    // fixed corners: all output-only with dir set, all bidi in, all bidi out
    apply('0, ONES, 20'hF0F0F, 20'hAAAAA);
    apply(ONES, ONES, 20'h0F0F0, 20'h55555);
    apply(ONES, '0, 20'hFFFFF, 20'h33333);
    // direction word 0x08 with pins 0..6 bidirectional
    apply(20'h0007F, 20'h00008, 20'h12345, 20'hFFFFF);
    check("R4 pin3 only released", pad_oe, ONES & ~20'h00008);

    // walking one per pin in mode and direction
    for (int i = 0; i < NPIN; i++) begin
      apply(NPIN'(1) << i, NPIN'(1) << i, ~(NPIN'(1) << i), ONES);
      check("R4 walking pin released", ~pad_oe, NPIN'(1) << i);
      check("R7 walking pin input", gpi_word, NPIN'(1) << i);
    end

    // pseudo-random sweep
    for (int k = 0; k < 200; k++) begin
      rng = xs(rng); m = rng[NPIN-1:0];
      rng = xs(rng); d = rng[NPIN-1:0];
      rng = xs(rng); o = rng[NPIN-1:0];
      rng = xs(rng); p = rng[NPIN-1:0];
      apply(m, d, o, p);
    end

    // R9 strobe low: no change at either address
    apply(20'hC3C3C, 20'h96969, 20'h0, 20'hFFFFF);
    for (int a = 0; a < 2; a++) begin
      @(negedge clk);
      cfg_we = 1'b0; cfg_addr = a[0]; cfg_wdata = 20'h13579;
      @(negedge clk);
    end
    rd(1'b0, "R9 mode unchanged", 20'hC3C3C);
    rd(1'b1, "R9 dir unchanged", 20'h96969);
    check_state(20'hC3C3C, 20'h96969, 20'hFFFFF);

    // R7 latency: a pad edge shows after exactly two rising edges
    apply(ONES, ONES, '0, '0);
    pad_in = 20'hABCDE;
    @(negedge clk);
    check("R7 one edge later still old", gpi_word, '0);
    @(negedge clk);
    check("R7 two edges later new", gpi_word, 20'hABCDE);

    // R1 mid-run reset clears configuration
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, "R1 mode after reset", '0);
    rd(1'b1, "R1 dir after reset", '0);
    check("R1 pad enable after reset", pad_oe, ONES);
    check("R1 input after reset", gpi_word, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule